// File: doc/BRIEF.md
# Two-Register Command Write Slave

This block is the serial-bus front end of a small control chip. It listens to an I2C-compatible two-wire bus through a system clock. It detects START, repeated START and STOP conditions, and it accepts write frames aimed at its own 7-bit address. The upper six address bits are fixed at `101000`. The lowest bit follows a strap pin, so two chips can share one bus.

A write frame carries no register pointer. The first data byte after the address always lands in command register 0x00, and the second data byte lands in register 0x01. Register 0x01 can therefore only be written together with 0x00. The slave acknowledges the matching address and each accepted data byte. A byte is committed, with a one-cycle strobe, only once its acknowledge clock has ended. Both register values are presented continuously to the chip's control logic.

Writes are accepted regardless of the chip's power mode. The open-drain data line is modelled as an output-enable that pulls SDA low.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `101000` followed by the level of `addr_strap`, and whose bit 0 (R/W) is 0. The bus carries the address byte MSB first.
- R2: An address byte that does not match, or that has R/W = 1, receives no acknowledge. Following bytes are then ignored, receive no acknowledge and change no register, until the next START or STOP.
- R3: An acknowledge is driven by asserting `sda_oe` after the SCL falling edge that ends the 8th bit. The slave holds it through the 9th SCL high phase and releases it after the following falling edge. `sda_oe` is low during the 8th bit's high phase.
- R4: In a write frame, the first data byte goes to register 0x00 (`cmd0_q`) and the second data byte goes to register 0x01 (`cmd1_q`).
- R5: A data byte is committed only after the falling edge that ends its acknowledge clock, and not during the 9th SCL high phase. The matching strobe (`cmd0_upd` or `cmd1_upd`) pulses for exactly one cycle, in the same cycle the new value appears. The two strobes never pulse together.
- R6: A third or later data byte in one frame receives no acknowledge and is discarded.
- R7: A STOP ends the frame at any point. This includes the middle of a byte, in which case the partial byte is discarded. A frame with a single data byte leaves register 0x01 unchanged.
- R8: A STOP that occurs in the same SCL high period as the preceding START is ignored, and the frame continues.
- R9: A repeated START restarts the frame, so that the next data byte goes to register 0x00 again.
- R10: A pulse on SDA that is shorter than the `FILT_CYCLES` stable count is not seen as a bus event.
- R11: After reset both registers read 0x00, `sda_oe` is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap | input | 1 | Selects the address LSB |
| sda_oe | output | 1 | When high, the data line is pulled low |
| cmd0_q | output | 8 | Command register 0x00 |
| cmd1_q | output | 8 | Command register 0x01 |
| cmd0_upd | output | 1 | One-cycle strobe when register 0x00 is written |
| cmd1_upd | output | 1 | One-cycle strobe when register 0x01 is written |

## Verification
The checker watches, on every cycle, the timing rules that hold on any bus traffic:
- register values change only together with their strobe;
- each strobe lasts one cycle and the two strobes never pulse together;
- a strobe and an acknowledge edge appear only right after a filtered SCL falling edge;
- `sda_oe` is always released after a STOP.

Only the directed scenarios can show the rest:
- address decoding against the strap;
- which byte lands in which register;
- NACK of reads and of surplus bytes;
- the abort on a STOP in the middle of a byte, and the STOP ignored in the same high phase as its START;
- the restart on a repeated START;
- rejection of short spikes on SDA.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } slv_state_t;

  // Address byte: seven address bits then R/W in bit 0; only writes match.
  function automatic logic addr_hit(input logic [7:0] abyte,
                                    input logic [5:0] base,
                                    input logic       strap);
    return (abyte[7:1] == {base, strap}) && !abyte[0];
  endfunction

  // A data byte is taken while its position is inside the register bank.
  function automatic logic byte_taken(input int unsigned pos,
                                      input int unsigned nregs);
    return pos < nregs;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int unsigned STABLE = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise_evt,
  output logic scl_fall_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_evt    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt     = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise_evt = scl_f & ~scl_q;
  assign scl_fall_evt = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs #(
  parameter int unsigned DW    = 8,
  parameter int unsigned NREGS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREGS-1:0]    wr_vec,
  input  logic [DW-1:0]       wdata,
  output logic [NREGS*DW-1:0] q_flat,
  output logic [NREGS-1:0]    stb
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_flat[g*DW +: DW] <= '0;
        stb[g]             <= 1'b0;
      end else begin
        stb[g] <= wr_vec[g];
        if (wr_vec[g]) q_flat[g*DW +: DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter logic [5:0]  ADDR_BASE   = 6'b101000,
  parameter int unsigned FILT_CYCLES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_strap,
  output logic          sda_oe,
  output logic [DW-1:0] cmd0_q,
  output logic [DW-1:0] cmd1_q,
  output logic          cmd0_upd,
  output logic          cmd1_upd
);
  localparam int unsigned NREGS = 2;
  localparam int unsigned IDXW  = $clog2(NREGS + 1);
  localparam int unsigned BCW   = $clog2(DW + 1);

  logic scl_f, sda_f;
  logic start_evt, stop_evt, scl_rise_evt, scl_fall_evt;

  i2c_glitch_filter #(.STABLE(FILT_CYCLES)) u_flt_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  i2c_glitch_filter #(.STABLE(FILT_CYCLES)) u_flt_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise_evt(scl_rise_evt), .scl_fall_evt(scl_fall_evt));

  slv_state_t      state_q;
  logic [BCW-1:0]  bit_cnt_q;
  logic [DW-1:0]   shreg_q;
  logic [IDXW-1:0] idx_q;
  logic            take_q;
  logic            start_hold_q;
  logic            stop_ok;
  logic            commit;
  logic [NREGS-1:0] wr_vec;

  assign stop_ok = stop_evt & ~start_hold_q;
  assign commit  = (state_q == ST_DATA_ACK) & scl_fall_evt & take_q &
                   ~start_evt & ~stop_ok;

  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    assign wr_vec[g] = commit & (idx_q == IDXW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      shreg_q      <= '0;
      idx_q        <= '0;
      take_q       <= 1'b0;
      start_hold_q <= 1'b0;
      sda_oe       <= 1'b0;
    end else begin
      if (start_evt)         start_hold_q <= 1'b1;
      else if (scl_fall_evt) start_hold_q <= 1'b0;

      if (start_evt) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        sda_oe    <= 1'b0;
      end else if (stop_ok) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_evt) begin
              shreg_q   <= {shreg_q[DW-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_evt && bit_cnt_q == BCW'(DW)) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit(shreg_q, ADDR_BASE, addr_strap)) begin
                  sda_oe  <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                take_q  <= byte_taken(int'(idx_q), NREGS);
                sda_oe  <= byte_taken(int'(idx_q), NREGS);
                state_q <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall_evt) begin
              sda_oe    <= 1'b0;
              state_q   <= ST_DATA;
              bit_cnt_q <= '0;
              if (state_q == ST_DATA_ACK && take_q) idx_q <= idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [NREGS*DW-1:0] q_flat;
  logic [NREGS-1:0]    stb;

  i2c_cmd_regs #(.DW(DW), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .wdata(shreg_q),
    .q_flat(q_flat), .stb(stb));

  assign cmd0_q   = q_flat[0 +: DW];
  assign cmd1_q   = q_flat[DW +: DW];
  assign cmd0_upd = stb[0];
  assign cmd1_upd = stb[1];
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic [DW-1:0] cmd0_q,
  input logic [DW-1:0] cmd1_q,
  input logic          cmd0_upd,
  input logic          cmd1_upd,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          scl_fall_evt
);
  // R5
  reg0_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0_q != $past(cmd0_q)) |-> cmd0_upd);
  // R5
  reg1_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd1_q != $past(cmd1_q)) |-> cmd1_upd);
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0_upd || cmd1_upd) |=> !(cmd0_upd || cmd1_upd));
  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd0_upd && cmd1_upd));
  // R5
  commit_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0_upd || cmd1_upd) |-> $past(scl_fall_evt));
  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall_evt));
  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall_evt || stop_evt || start_evt));
  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe),
  .cmd0_q(cmd0_q), .cmd1_q(cmd1_q),
  .cmd0_upd(cmd0_upd), .cmd1_upd(cmd1_upd),
  .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall_evt(scl_fall_evt));

// File: tb/i2c_cmd_slave_bench.sv
module i2c_cmd_slave_bench;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1, strap = 1'b0;
  logic sda_oe, cmd0_upd, cmd1_upd;
  logic [7:0] cmd0_q, cmd1_q;
  wire  sda_line = sda_drv & ~sda_oe;

  int errors = 0, checks = 0, n0 = 0, n1 = 0;
  bit done = 0;
  logic [7:0] pre0, pre1;

  always #2 clk = ~clk;

  i2c_cmd_slave u_i2c_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .cmd0_q(cmd0_q), .cmd1_q(cmd1_q),
    .cmd0_upd(cmd0_upd), .cmd1_upd(cmd1_upd));

  always @(posedge clk) begin
    if (cmd0_upd) n0++;
    if (cmd1_upd) n1++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_drv = 1; wt(H); scl_drv = 1; wt(H); sda_drv = 0; wt(H); scl_drv = 0; wt(H);
  endtask

  task automatic bus_stop();
    sda_drv = 0; wt(H); scl_drv = 1; wt(H); sda_drv = 1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wt(H); scl_drv = 1; wt(H / 2);
      if (glitch && i == 7 && b[7]) begin
        sda_drv = 0; wt(5); sda_drv = 1;
      end
      wt(H / 2);
      if (i == 0) chk(sda_oe == 0, "R3 no drive in bit 8", sda_oe, 0);
      scl_drv = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    sda_drv = 1; wt(H); scl_drv = 1; wt(H / 2);
    ack = !sda_line; pre0 = cmd0_q; pre1 = cmd1_q;
    wt(H / 2); scl_drv = 0; wt(H);
  endtask

  task automatic t_reset();
    chk(cmd0_q == 0, "R11 reg0 reset", cmd0_q, 0);
    chk(cmd1_q == 0, "R11 reg1 reset", cmd1_q, 0);
    chk(sda_oe == 0 && n0 == 0 && n1 == 0, "R11 idle outputs", sda_oe, 0);
  endtask

  task automatic t_two_bytes();
    bit a;
    bus_start();
    send_byte(8'hA0, 0, a); chk(a, "R1 address ack strap0", a, 1);
    send_byte(8'h5A, 0, a); chk(a, "R3 data ack", a, 1);
    chk(pre0 == 8'h00, "R5 not committed during ack", pre0, 0);
    chk(cmd0_q == 8'h5A && n0 == 1, "R4 first byte to reg0", cmd0_q, 8'h5A);
    send_byte(8'hC3, 0, a);
    chk(cmd1_q == 8'hC3 && n1 == 1 && cmd0_q == 8'h5A, "R4 second byte to reg1", cmd1_q, 8'hC3);
    bus_stop();
  endtask

  task automatic t_one_byte();
    bit a;
    bus_start(); send_byte(8'hA0, 0, a); send_byte(8'h11, 0, a); bus_stop();
    chk(cmd0_q == 8'h11, "R7 single byte reg0", cmd0_q, 8'h11);
    chk(cmd1_q == 8'hC3 && n1 == 1, "R7 reg1 kept", cmd1_q, 8'hC3);
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start(); send_byte(8'hA2, 0, a);
    chk(!a, "R1 other strap address nack", a, 0);
    send_byte(8'h77, 0, a); bus_stop();
    chk(!a && cmd0_q == 8'h11, "R2 ignored after mismatch", cmd0_q, 8'h11);
  endtask

  task automatic t_read();
    bit a;
    bus_start(); send_byte(8'hA1, 0, a);
    chk(!a, "R2 read nack", a, 0);
    send_byte(8'h78, 0, a); bus_stop();
    chk(!a && cmd0_q == 8'h11 && n0 == 2, "R2 read frame ignored", cmd0_q, 8'h11);
  endtask

  task automatic t_strap_and_surplus();
    bit a;
    strap = 1; wt(H);
    bus_start(); send_byte(8'hA0, 0, a); bus_stop();
    chk(!a, "R1 strap1 rejects A0", a, 0);
    bus_start(); send_byte(8'hA2, 0, a);
    chk(a, "R1 strap1 accepts A2", a, 1);
    send_byte(8'h22, 0, a); send_byte(8'h33, 0, a); send_byte(8'h44, 0, a);
    chk(!a, "R6 third byte nack", a, 0);
    bus_stop();
    chk(cmd0_q == 8'h22 && cmd1_q == 8'h33 && n0 == 3 && n1 == 2,
        "R6 third byte discarded", cmd1_q, 8'h33);
  endtask

  task automatic t_stop_mid();
    bit a;
    bus_start(); send_byte(8'hA2, 0, a); send_bits(8'h99, 4, 0); bus_stop();
    send_byte(8'h99, 0, a);
    chk(!a && cmd0_q == 8'h22 && n0 == 3, "R7 stop mid byte aborts", cmd0_q, 8'h22);
  endtask

  task automatic t_rep_start();
    bit a;
    bus_start(); send_byte(8'hA2, 0, a); send_byte(8'h10, 0, a);
    bus_start(); send_byte(8'hA2, 0, a); send_byte(8'h20, 0, a); bus_stop();
    chk(cmd0_q == 8'h20 && cmd1_q == 8'h33 && n0 == 5, "R9 repeated start to reg0", cmd0_q, 8'h20);
  endtask

  task automatic t_start_stop_same_high();
    bit a;
    sda_drv = 1; wt(H); scl_drv = 1; wt(H); sda_drv = 0; wt(H);
    sda_drv = 1; wt(H); scl_drv = 0; wt(H);
    send_byte(8'hA2, 0, a);
    chk(a, "R8 stop in start high ignored", a, 1);
    send_byte(8'h66, 0, a); bus_stop();
    chk(cmd0_q == 8'h66, "R8 frame continued", cmd0_q, 8'h66);
  endtask

  task automatic t_glitch();
    bit a;
    bus_start(); send_byte(8'hA2, 0, a); send_byte(8'h81, 1, a); bus_stop();
    chk(a && cmd0_q == 8'h81, "R10 spike rejected", cmd0_q, 8'h81);
  endtask

  initial begin
    wt(10); rst_n = 1; wt(10);
    t_reset();
    t_two_bytes();
    t_one_byte();
    t_wrong_addr();
    t_read();
    t_strap_and_surplus();
    t_stop_mid();
    t_rep_start();
    t_start_stop_same_high();
    t_glitch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule